// File: doc/BRIEF.md
# Two-Line Interrupt Aggregation Controller

This block collects interrupt causes from two groups of on-chip sources and presents them on two active-high host request lines. Group 0 is the packet-transport block. Each of its sources sends a one-cycle event pulse into a sticky pending register. A per-bit mask sits after that register, and a mask bit of 1 blocks its source from the output. Group 1 covers the line interface, the framer and the bit-error tester. These arrive already combined as a single level request.

A host reaches the pending register, the mask register and a small configuration register through a plain address/write-enable/data port. Reads come back combinationally. Pending bits are cleared by writing ones to them. One configuration bit merges the two lines. When that bit is set, line 1 stays quiet and the group-1 request is folded into line 0, so a single pin reports every source.

Top module: `irqAggTop`

## Requirements
- R1: `irqOut0` is a register. After each clock edge it holds the OR over all bits of (pending AND NOT mask) as they were before that edge, ORed with (merge AND `lineReq`).
- R2: While the merge bit is 0, `irqOut1` follows `lineReq` one clock edge later.
- R3: While the merge bit is 1, `irqOut1` is 0 after every edge, and `lineReq` drives `irqOut0` instead (per R1).
- R4: Writing to address 0 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: Reset gives pending = 0, mask = all ones, merge = 0, and both outputs 0.
- R6: Address 1 is the mask register, read/write. A mask bit of 0 lets its pending bit assert `irqOut0`. A mask bit of 1 blocks it.
- R7: A pulse on `srcEvent[i]` sets pending bit i on the next edge whatever the mask, so masked events can be polled.
- R8: If an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Address 2 bit 0 is the merge bit, read/write, and the other bits read 0. Address 3 reads 0 and ignores writes. `regRdData` reflects the addressed register in the same cycle, and a read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | 8 | One-cycle event pulses from packet-transport sources |
| lineReq | input | 1 | Level request from line/framer/BER-tester group |
| regAddr | input | 2 | Register address (0 pending, 1 mask, 2 config, 3 unused) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the addressed register, combinational |
| irqOut0 | output | 1 | Host request line 0 (active high) |
| irqOut1 | output | 1 | Host request line 1 (active high) |

## Verification
Register effects appear one edge after the write or event. Read data can therefore be compared at the falling edge that follows. A change in `lineReq` reaches the outputs after one edge. An event or a mask write must pass through the pending or mask register and then the output register, so it reaches `irqOut0` after two edges. The bench's reference model advances at each rising edge using only the inputs and its own state. Its outputs are compared with the design on every falling edge, before new stimulus is applied. Because of this, each result is checked exactly in the cycle it is due.

// File: rtl/irqAggPkg.sv
package irqAggPkg;

  typedef enum logic [1:0] {
    SelPend = 2'd0,
    SelMask = 2'd1,
    SelCfg  = 2'd2,
    SelNone = 2'd3
  } regSelT;

  typedef struct packed {
    logic wrPend;
    logic wrMask;
    logic wrCfg;
  } strobeT;

endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int AddrW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWrEn,
  output strobeT           strb,
  output regSelT           rdSel
);

  always_comb begin
    strb  = '0;
    rdSel = regSelT'(regAddr[1:0]);
    if (regWrEn) begin
      case (regSelT'(regAddr[1:0]))
        SelPend: strb.wrPend = 1'b1;
        SelMask: strb.wrMask = 1'b1;
        SelCfg:  strb.wrCfg  = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  // R9: at most one register is written per cycle; address 3 writes nothing
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPend, strb.wrMask, strb.wrCfg}));

  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SelNone) |-> (strb == '0));

endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NumSrc = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  regSelT            rdSel,
  input  logic [NumSrc-1:0] wrData,
  input  logic [NumSrc-1:0] srcEvent,
  input  logic              lineReq,
  output logic [NumSrc-1:0] rdData,
  output logic              irq0,
  output logic              irq1
);

  logic [NumSrc-1:0] pendQ, pendD, maskQ, clrBits, enabled;
  logic mergeQ, irq0Q, irq1Q;

  assign clrBits = strb.wrPend ? wrData : '0;

  // per-source sticky bit: event has priority over the clear (R8)
  for (genvar i = 0; i < NumSrc; i++) begin : gPend
    assign pendD[i] = srcEvent[i] | (pendQ[i] & ~clrBits[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      maskQ  <= '1;
      mergeQ <= 1'b0;
    end else begin
      pendQ <= pendD;
      if (strb.wrMask) maskQ  <= wrData;
      if (strb.wrCfg)  mergeQ <= wrData[0];
    end
  end

  assign enabled = pendQ & ~maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq0Q <= 1'b0;
      irq1Q <= 1'b0;
    end else begin
      irq0Q <= (|enabled) | (mergeQ & lineReq);
      irq1Q <= lineReq & ~mergeQ;
    end
  end

  assign irq0 = irq0Q;
  assign irq1 = irq1Q;

  always_comb begin
    case (rdSel)
      SelPend: rdData = pendQ;
      SelMask: rdData = maskQ;
      SelCfg:  rdData = {{(NumSrc-1){1'b0}}, mergeQ};
      default: rdData = '0;
    endcase
  end

  // R4: a set bit only drops when a 1 was written to it
  assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(pendQ) & ~$past(clrBits)) & ~pendQ) == '0));

  // R7/R8: every event lands in pending, masked or cleared or not
  assert_event_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((pendQ & $past(srcEvent)) == $past(srcEvent)));

  // R1/R6: an unmasked pending bit raises line 0 on the next edge
  assert_unmasked_fires_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|enabled) |=> irq0Q);

  // R6: with nothing enabled and no merge, line 0 stays low
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!mergeQ && enabled == '0) |=> !irq0Q);

  // R3: merged mode silences line 1
  assert_merge_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    mergeQ |=> !irq1Q);

  // R2: unmerged line 1 follows the group-1 request
  assert_line1_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!mergeQ && lineReq) |=> irq1Q);

endmodule

// File: rtl/irqAggTop.sv
module irqAggTop
  import irqAggPkg::*;
#(
  parameter int NumSrc = 8,
  parameter int AddrW  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcEvent,
  input  logic              lineReq,
  input  logic [AddrW-1:0]  regAddr,
  input  logic              regWrEn,
  input  logic [NumSrc-1:0] regWrData,
  output logic [NumSrc-1:0] regRdData,
  output logic              irqOut0,
  output logic              irqOut1
);

  strobeT strb;
  regSelT rdSel;

  irqAggCtrl #(.AddrW(AddrW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  irqAggDatapath #(.NumSrc(NumSrc)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .srcEvent (srcEvent),
    .lineReq  (lineReq),
    .rdData   (regRdData),
    .irq0     (irqOut0),
    .irq1     (irqOut1)
  );

endmodule

// File: tb/tb_irqAggTop.sv
module tb_irqAggTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcEvent = '0;
  logic       lineReq = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut0, irqOut1;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string tag = "R5";

  // reference model state
  logic [7:0] mPend = '0;
  logic [7:0] mMask = 8'hFF;
  logic       mMerge = 1'b0;
  logic       mIrq0 = 1'b0;
  logic       mIrq1 = 1'b0;

  always #2 clk = ~clk;

  irqAggTop dut (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .lineReq(lineReq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut0(irqOut0), .irqOut1(irqOut1)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mMask = 8'hFF; mMerge = 1'b0; mIrq0 = 1'b0; mIrq1 = 1'b0;
    end else begin
      logic [7:0] nPend, nMask;
      logic nMerge;
      nPend = mPend;
      nMask = mMask;
      nMerge = mMerge;
      if (regWrEn && regAddr == 2'd0) nPend = nPend & ~regWrData;
      nPend = nPend | srcEvent;
      if (regWrEn && regAddr == 2'd1) nMask = regWrData;
      if (regWrEn && regAddr == 2'd2) nMerge = regWrData[0];
      mIrq0 = ((mPend & ~mMask) != 0) || (mMerge && lineReq);
      mIrq1 = lineReq && !mMerge;
      mPend = nPend; mMask = nMask; mMerge = nMerge;
    end
  end

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mPend;
      2'd1: return mMask;
      2'd2: return {7'b0, mMerge};
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    cmp("regRdData", regRdData, expRead(regAddr));
    cmp("irqOut0", {7'b0, irqOut0}, {7'b0, mIrq0});
    cmp("irqOut1", {7'b0, irqOut1}, {7'b0, mIrq1});
  endtask

  task automatic step(input logic [7:0] ev, input logic req, input logic we,
                      input logic [1:0] a, input logic [7:0] wd);
    @(negedge clk);
    checkAll();
    srcEvent = ev; lineReq = req; regWrEn = we; regAddr = a; regWrData = wd;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int k = 0; k < n; k++) step(8'h00, lineReq, 1'b0, a, 8'h00);
  endtask

  initial begin
    // R5: reset values, read mask under reset
    tag = "R5";
    step(8'h00, 1'b0, 1'b0, 2'd1, 8'h00);
    step(8'h00, 1'b0, 1'b0, 2'd1, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    idle(2, 2'd1);
    idle(1, 2'd0);
    idle(1, 2'd2);

    // R7: masked event is latched but silent
    tag = "R7";
    step(8'h08, 1'b0, 1'b0, 2'd0, 8'h00);
    idle(3, 2'd0);

    // R6: unmask bit 3 -> line 0 rises two edges later
    tag = "R6";
    step(8'h00, 1'b0, 1'b1, 2'd1, 8'hF7);
    idle(3, 2'd1);

    // R4: writing zeros leaves pending; writing one clears
    tag = "R4";
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'h00);
    idle(2, 2'd0);
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'h08);
    idle(3, 2'd0);

    // R8: set and clear collide on bit 2
    tag = "R8";
    step(8'h04, 1'b0, 1'b0, 2'd0, 8'h00);
    step(8'h04, 1'b0, 1'b1, 2'd0, 8'h04);
    idle(3, 2'd0);
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'hFF);
    idle(2, 2'd0);

    // R2: group-1 level request on line 1
    tag = "R2";
    step(8'h00, 1'b1, 1'b0, 2'd2, 8'h00);
    idle(3, 2'd2);
    step(8'h00, 1'b0, 1'b0, 2'd2, 8'h00);
    idle(2, 2'd2);

    // R3: merge folds line 1 into line 0
    tag = "R3";
    step(8'h00, 1'b1, 1'b1, 2'd2, 8'h01);
    idle(3, 2'd2);
    step(8'h00, 1'b0, 1'b0, 2'd2, 8'h00);
    idle(2, 2'd2);
    step(8'h00, 1'b1, 1'b1, 2'd2, 8'hFE);
    idle(3, 2'd2);
    step(8'h00, 1'b0, 1'b0, 2'd2, 8'h00);

    // R9: unused address reads zero, writes ignored, reads side-effect free
    tag = "R9";
    step(8'h10, 1'b0, 1'b0, 2'd0, 8'h00);
    step(8'h00, 1'b0, 1'b1, 2'd3, 8'hFF);
    idle(1, 2'd3);
    idle(1, 2'd0);
    idle(2, 2'd0);
    idle(1, 2'd1);
    idle(1, 2'd2);

    // R1: random mixed traffic
    tag = "R1";
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ev;
      logic [1:0] a;
      ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      a = 2'($urandom);
      step(ev, 1'($urandom), ($urandom % 3 == 0), a, 8'($urandom));
    end
    idle(3, 2'd0);

    @(negedge clk);
    checkAll();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule